// File: doc/BRIEF.md
# Vector Logic and Arithmetic Unit

This block runs the bitwise and integer-add families of a small vector instruction set against a 128-entry, 32-bit register file that sits outside it. One 32-bit instruction word names a first source register, a second operand (a register that steps along with the element index, a register held fixed, or a small signed immediate), a destination register and an element count. Once the instruction is accepted, the unit streams one element per cycle: it reads the operands through two combinational read ports, computes the result and drives one write port in that same cycle.

A master presents a word with `insn_valid`. The unit takes it when `insn_ready` is high and holds `insn_ready` low while the elements run. `done` marks the cycle of the last element. Two further operations come with the plain forms. One reduces a run of registers into a single sum. The other builds an absolute value from an add or a subtract chosen by the sign of the second operand. Register 0 always reads as zero and can never be written.

Top module: `vec_alu_unit`

## Requirements
- R1: After reset `insn_ready` is high and `done` and `wr_en` are low. A word is taken on a clock edge where `insn_valid` and `insn_ready` are both high. For a recognised word `insn_ready` then stays low up to and including the cycle in which `done` is high, and is high again in the cycle after that.
- R2: The instruction fields are: group at bits 31:28, element count at 27:24, sub-operation at 23:21, source A at 20:14, destination at 13:7 and source B at 6:0. Group 0xB selects the logic set and group 0xA the arithmetic set. A word with any other group value is taken, produces no write and no `done`, and leaves `insn_ready` high.
- R3: A recognised instruction with count field c covers elements 0..c. Element k is handled in cycle k+1 after the accepting edge. `done` is high only in cycle c+1.
- R4: Logic sub-operations: 0 AND with stepped B, 1 AND with fixed B, 2 AND with immediate, 3 XOR with stepped B, 4 XOR with fixed B, 5 XOR with immediate, 6 OR with stepped B, 7 OR with fixed B.
- R5: Arithmetic sub-operations: 0 A+B stepped, 1 A+B fixed, 2 A+immediate, 4 A−B stepped, 5 A−B fixed, 6 A−immediate. Every result wraps modulo 2^32.
- R6: Element k reads A at (A+k) mod 128 and writes (D+k) mod 128. In the stepped forms B is read at (B+k) mod 128. In the fixed forms B is read at B for every element.
- R7: In the immediate forms the 7-bit B field, sign-extended to 32 bits, is the second operand.
- R8: Arithmetic sub-operation 3 adds register B to the registers A..A+c, wrapping modulo 2^32. It writes only the total, once, to D, in the cycle where `done` is high.
- R9: Arithmetic sub-operation 7 holds A fixed and steps B and D. It writes A−B when bit 31 of B is set and A+B otherwise, so A = register 0 gives the absolute value.
- R10: Register 0 reads as zero whatever the read port returns, and `wr_en` is never high with `wr_addr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word present |
| insn_ready | output | 1 | Unit can take a word this cycle |
| insn_word | input | 32 | Instruction word |
| rf_a_addr | output | 7 | Register index for operand A |
| rf_a_data | input | DATA_W | Register contents at `rf_a_addr`, same cycle |
| rf_b_addr | output | 7 | Register index for operand B |
| rf_b_data | input | DATA_W | Register contents at `rf_b_addr`, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register write index |
| wr_data | output | DATA_W | Register write value |
| done | output | 1 | Last element of the current instruction |

## Verification
Element k of an accepted word is due in the (k+1)-th cycle after the accepting edge, and its write lands in the register file at the edge that closes that cycle. So `done` is due exactly c+1 cycles after acceptance and `insn_ready` one cycle later. The bench counts falling edges from the accepting edge, samples `done` and `insn_ready` at the count these figures give, and compares the whole register file with its own sequential model only after the edge that follows `done`. Words with an unknown group are watched for three cycles, with no write and no `done` expected.

// File: rtl/vau_pkg.sv
// Package vau_pkg
// Shared field positions, operation codes and the decoded micro-op record
// used by every module of the vector logic/arithmetic unit.
// Assumes a fixed 32-bit instruction word and a 128-entry register file.
package vau_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_AW   = 7;
    localparam int CNT_W    = 4;
    localparam int IMM_W    = 7;

    localparam int GRP_LSB  = 28;
    localparam int CNT_LSB  = 24;
    localparam int SUB_LSB  = 21;
    localparam int SRCA_LSB = 14;
    localparam int DST_LSB  = 7;
    localparam int SRCB_LSB = 0;

    localparam logic [3:0] GRP_LOGIC = 4'hB;
    localparam logic [3:0] GRP_ARITH = 4'hA;

    // Where the second operand comes from.
    typedef enum logic [1:0] {
        BSRC_STEP  = 2'd0,
        BSRC_FIXED = 2'd1,
        BSRC_IMM   = 2'd2
    } bsrc_e;

    // Function performed on each element.
    typedef enum logic [2:0] {
        FN_AND = 3'd0,
        FN_XOR = 3'd1,
        FN_OR  = 3'd2,
        FN_ADD = 3'd3,
        FN_SUB = 3'd4,
        FN_SUM = 3'd5,
        FN_ABS = 3'd6
    } fn_e;

    typedef struct packed {
        logic              known;
        fn_e               fn;
        bsrc_e             bsrc;
        logic              a_step;
        logic              d_step;
        logic [CNT_W-1:0]  cnt;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rb;
    } uop_t;

endpackage

// File: rtl/vau_decode.sv
// Module vau_decode
// Turns a raw instruction word into a micro-op: function, operand source,
// stepping flags and register fields. Purely combinational.
// Assumes the word layout held in vau_pkg; groups other than logic and
// arithmetic come out with known = 0.
module vau_decode
    import vau_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output uop_t              uop
);

    logic [3:0] grp;
    logic [2:0] sub;

    assign grp = word[GRP_LSB +: 4];
    assign sub = word[SUB_LSB +: 3];

    // Field extraction and per-group sub-operation mapping.
    always_comb begin
        uop        = '0;
        uop.cnt    = word[CNT_LSB  +: CNT_W];
        uop.ra     = word[SRCA_LSB +: REG_AW];
        uop.rd     = word[DST_LSB  +: REG_AW];
        uop.rb     = word[SRCB_LSB +: REG_AW];
        uop.a_step = 1'b1;
        uop.d_step = 1'b1;
        uop.fn     = FN_AND;
        uop.bsrc   = BSRC_STEP;
        if (grp == GRP_LOGIC) begin
            uop.known = 1'b1;
            case (sub)
                3'd0: begin uop.fn = FN_AND; uop.bsrc = BSRC_STEP;  end
                3'd1: begin uop.fn = FN_AND; uop.bsrc = BSRC_FIXED; end
                3'd2: begin uop.fn = FN_AND; uop.bsrc = BSRC_IMM;   end
                3'd3: begin uop.fn = FN_XOR; uop.bsrc = BSRC_STEP;  end
                3'd4: begin uop.fn = FN_XOR; uop.bsrc = BSRC_FIXED; end
                3'd5: begin uop.fn = FN_XOR; uop.bsrc = BSRC_IMM;   end
                3'd6: begin uop.fn = FN_OR;  uop.bsrc = BSRC_STEP;  end
                default: begin uop.fn = FN_OR; uop.bsrc = BSRC_FIXED; end
            endcase
        end else if (grp == GRP_ARITH) begin
            uop.known = 1'b1;
            case (sub)
                3'd0: begin uop.fn = FN_ADD; uop.bsrc = BSRC_STEP;  end
                3'd1: begin uop.fn = FN_ADD; uop.bsrc = BSRC_FIXED; end
                3'd2: begin uop.fn = FN_ADD; uop.bsrc = BSRC_IMM;   end
                3'd3: begin
                    uop.fn     = FN_SUM;
                    uop.bsrc   = BSRC_FIXED;
                    uop.d_step = 1'b0;
                end
                3'd4: begin uop.fn = FN_SUB; uop.bsrc = BSRC_STEP;  end
                3'd5: begin uop.fn = FN_SUB; uop.bsrc = BSRC_FIXED; end
                3'd6: begin uop.fn = FN_SUB; uop.bsrc = BSRC_IMM;   end
                default: begin
                    uop.fn     = FN_ABS;
                    uop.bsrc   = BSRC_STEP;
                    uop.a_step = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vau_seq.sv
// Module vau_seq
// Instruction handshake and element sequencer. Takes one word while idle,
// holds its micro-op and walks an element index from 0 to the count.
// Assumes a word with an unknown group is consumed without starting a run.
module vau_seq
    import vau_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  uop_t             uop_in,
    output logic             insn_ready,
    output uop_t             uop_q,
    output logic             busy,
    output logic [CNT_W-1:0] idx,
    output logic             first,
    output logic             last
);

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

    seq_state_e state;
    logic       accept;

    assign insn_ready = (state == ST_IDLE);
    assign accept     = insn_valid && insn_ready;
    assign busy       = (state == ST_RUN);
    assign first      = (idx == '0);
    assign last       = (idx == uop_q.cnt);

    // State, latched micro-op and element index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            uop_q <= '0;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && uop_in.known) begin
                        state <= ST_RUN;
                        uop_q <= uop_in;
                        idx   <= '0;
                    end
                end
                default: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_TAKEN_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && uop_in.known) |=> !insn_ready); // R1

    AST_UNKNOWN_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !uop_in.known) |=> insn_ready); // R2

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= uop_q.cnt)); // R3

    AST_RUN_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last) |=> insn_ready); // R1

endmodule

// File: rtl/vau_exec.sv
// Module vau_exec
// Per-element datapath: forms the three register indices from the element
// index, masks register 0 to zero, picks the second operand, computes the
// result and gates the write. Keeps one accumulator for the reduction sum.
// Assumes the register file answers reads in the same cycle.
module vau_exec
    import vau_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [CNT_W-1:0]  idx,
    input  logic              first,
    input  logic              last,
    input  fn_e               fn,
    input  bsrc_e             bsrc,
    input  logic              a_step,
    input  logic              d_step,
    input  logic [REG_AW-1:0] ra,
    input  logic [REG_AW-1:0] rd,
    input  logic [REG_AW-1:0] rb,
    output logic [REG_AW-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    output logic [REG_AW-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    localparam int PAD_W = REG_AW - CNT_W;

    logic [REG_AW-1:0] step;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] breg;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_next;
    logic [DATA_W-1:0] result;
    logic              write_slot;

    assign step    = {{PAD_W{1'b0}}, idx};
    assign a_addr  = a_step ? (ra + step) : ra;
    assign b_addr  = (bsrc == BSRC_STEP) ? (rb + step) : rb;
    assign wr_addr = d_step ? (rd + step) : rd;

    // Register 0 always reads as zero.
    assign opa     = (a_addr == '0) ? '0 : a_data;
    assign breg    = (b_addr == '0) ? '0 : b_data;
    assign imm_ext = {{(DATA_W-IMM_W){rb[IMM_W-1]}}, rb};
    assign opb     = (bsrc == BSRC_IMM) ? imm_ext : breg;

    // Running total for the reduction: seeded with B on the first element.
    assign acc_next = first ? (opa + opb) : (acc_q + opa);

    // Element result selection.
    always_comb begin
        case (fn)
            FN_AND:  result = opa & opb;
            FN_XOR:  result = opa ^ opb;
            FN_OR:   result = opa | opb;
            FN_ADD:  result = opa + opb;
            FN_SUB:  result = opa - opb;
            FN_SUM:  result = acc_next;
            default: result = opb[DATA_W-1] ? (opa - opb) : (opa + opb);
        endcase
    end

    // Accumulator update on every running element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (busy) begin
            acc_q <= acc_next;
        end
    end

    assign write_slot = busy && ((fn != FN_SUM) || last);
    assign wr_en      = write_slot && (wr_addr != '0);
    assign wr_data    = result;
    assign done       = busy && last;

    AST_DEST_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && d_step) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R6

    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_SUM_WRITES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (fn == FN_SUM)) |-> done); // R8

    AST_FIXED_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !first && (bsrc == BSRC_FIXED)) |-> (b_addr == $past(b_addr))); // R6

endmodule

// File: rtl/vec_alu_unit.sv
// Module vec_alu_unit
// Top of the vector logic/arithmetic unit: decodes the offered word,
// sequences elements and streams one register-file write per cycle.
// Assumes an external register file with two same-cycle read ports and
// one write port that commits at the rising edge.
module vec_alu_unit
    import vau_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    output logic              insn_ready,
    input  logic [31:0]       insn_word,
    output logic [6:0]        rf_a_addr,
    input  logic [DATA_W-1:0] rf_a_data,
    output logic [6:0]        rf_b_addr,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic              wr_en,
    output logic [6:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    uop_t             dec_uop;
    uop_t             run_uop;
    logic             busy;
    logic [CNT_W-1:0] idx;
    logic             first;
    logic             last;

    vau_decode u_decode (
        .word (insn_word),
        .uop  (dec_uop)
    );

    vau_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .uop_in     (dec_uop),
        .insn_ready (insn_ready),
        .uop_q      (run_uop),
        .busy       (busy),
        .idx        (idx),
        .first      (first),
        .last       (last)
    );

    vau_exec #(.DATA_W(DATA_W)) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy && run_uop.known),
        .idx     (idx),
        .first   (first),
        .last    (last),
        .fn      (run_uop.fn),
        .bsrc    (run_uop.bsrc),
        .a_step  (run_uop.a_step),
        .d_step  (run_uop.d_step),
        .ra      (run_uop.ra),
        .rd      (run_uop.rd),
        .rb      (run_uop.rb),
        .a_addr  (rf_a_addr),
        .a_data  (rf_a_data),
        .b_addr  (rf_b_addr),
        .b_data  (rf_b_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (done)
    );

    AST_NO_WRITE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        insn_ready |-> (!wr_en && !done)); // R1

    AST_REG0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_addr == 7'd0)) |-> !wr_en); // R10

endmodule

// File: tb/vec_alu_unit_test.sv
`timescale 1ns/1ps
module vec_alu_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        insn_ready;
    logic [6:0]  rf_a_addr, rf_b_addr, wr_addr;
    logic [31:0] rf_a_data, rf_b_data, wr_data;
    logic        wr_en, done;

    logic [31:0] mem [128];
    logic [31:0] gm  [128];
    logic [31:0] ex  [128];
    logic        sync_req = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vec_alu_unit uut (
        .clk (clk), .rst_n (rst_n),
        .insn_valid (insn_valid), .insn_ready (insn_ready), .insn_word (insn_word),
        .rf_a_addr (rf_a_addr), .rf_a_data (rf_a_data),
        .rf_b_addr (rf_b_addr), .rf_b_data (rf_b_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .done (done)
    );

    // Register file model: same-cycle reads, write at the rising edge.
    assign rf_a_data = mem[rf_a_addr];
    assign rf_b_data = mem[rf_b_addr];
    always @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        else if (sync_req) for (int k = 0; k < 128; k++) mem[k] <= gm[k];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdx(input logic [6:0] r);
        return (r == 7'd0) ? 32'd0 : ex[r];
    endfunction

    // Sequential reference of one word over ex[] (R4..R10).
    task automatic model(input logic [31:0] w);
        logic [3:0] grp; logic [3:0] cnt; logic [2:0] sub;
        logic [6:0] ra, rd, rb, ai, bi, di;
        logic [31:0] a, b, r, acc;
        bit imm, fixb, aheld, dheld;
        grp = w[31:28]; cnt = w[27:24]; sub = w[23:21];
        ra = w[20:14]; rd = w[13:7]; rb = w[6:0];
        if (grp != 4'hA && grp != 4'hB) return;
        imm   = (sub == 3'd2) || (grp == 4'hB && sub == 3'd5) || (grp == 4'hA && sub == 3'd6);
        fixb  = (grp == 4'hB) ? (sub == 1 || sub == 4 || sub == 7) : (sub == 1 || sub == 3 || sub == 5);
        aheld = (grp == 4'hA && sub == 3'd7);
        dheld = (grp == 4'hA && sub == 3'd3);
        acc = 0;
        for (int i = 0; i <= int'(cnt); i++) begin
            ai = aheld ? ra : ra + 7'(i);
            bi = fixb ? rb : rb + 7'(i);
            di = dheld ? rd : rd + 7'(i);
            a  = rdx(ai);
            b  = imm ? {{25{rb[6]}}, rb} : rdx(bi);
            if (grp == 4'hB) begin
                case (sub)
                    0, 1, 2: r = a & b;
                    3, 4, 5: r = a ^ b;
                    default: r = a | b;
                endcase
            end else begin
                case (sub)
                    0, 1, 2: r = a + b;
                    3: begin acc = (i == 0) ? a + b : acc + a; r = acc; end
                    4, 5, 6: r = a - b;
                    default: r = b[31] ? a - b : a + b;
                endcase
            end
            if (!(dheld && i != int'(cnt)) && di != 7'd0) ex[di] = r;
        end
    endtask

    task automatic fill(input int flavour);
        for (int k = 0; k < 128; k++) begin
            case (flavour)
                0: gm[k] = $urandom();
                1: gm[k] = (k % 3 == 0) ? 32'hFFFF_FFFF : ((k % 3 == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF);
                default: gm[k] = 32'(k) * 32'h0101_0101 ^ 32'hA5A5_0000;
            endcase
        end
    endtask

    task automatic run_word(input logic [31:0] w, input string tag);
        int done_at, rdy_seen, nwr, span, bad;
        bit r0w, known;
        logic [3:0] cnt;
        known = (w[31:28] == 4'hA) || (w[31:28] == 4'hB);
        cnt   = w[27:24];
        for (int k = 0; k < 128; k++) ex[k] = gm[k];
        model(w);
        sync_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sync_req   = 1'b0;
        insn_valid = 1'b1;
        insn_word  = w;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        done_at = 0; rdy_seen = 0; nwr = 0; r0w = 0;
        span = known ? int'(cnt) + 1 : 3;
        for (int k = 1; k <= span; k++) begin
            if (done && done_at == 0) done_at = k;
            if (insn_ready) rdy_seen++;
            if (wr_en) nwr++;
            if (wr_en && wr_addr == 7'd0) r0w = 1;
            @(negedge clk);
        end
        if (known) begin
            check(done_at == int'(cnt) + 1, "R3", "done cycle", 32'(done_at), 32'(int'(cnt) + 1));
            check(rdy_seen == 0 && insn_ready, "R1", "ready low during run then high",
                  32'(rdy_seen), 32'd0);
            check(!r0w, "R10", "write to register 0", 32'(r0w), 32'd0);
        end else begin
            check(done_at == 0 && nwr == 0 && rdy_seen == 3, "R2", "unknown group ignored",
                  32'(nwr), 32'd0);
        end
        bad = -1;
        for (int k = 127; k >= 0; k--) if (mem[k] !== ex[k]) bad = k;
        if (bad >= 0) check(0, tag, $sformatf("register %0d after word %h", bad, w), mem[bad], ex[bad]);
        else          check(1, tag, "register file", 32'd0, 32'd0);
        for (int k = 0; k < 128; k++) gm[k] = ex[k];
    endtask

    function automatic logic [31:0] enc(input logic [3:0] g, input logic [3:0] c,
            input logic [2:0] s, input logic [6:0] a, input logic [6:0] d, input logic [6:0] b);
        return {g, c, s, a, d, b};
    endfunction

    function automatic string tag_of(input logic [3:0] g, input logic [2:0] s);
        string t;
        if (g == 4'hB) t = "R4 R2";
        else if (s == 3'd3) t = "R8";
        else if (s == 3'd7) t = "R9";
        else t = "R5";
        if ((s == 3'd2) || (g == 4'hB && s == 3'd5) || (g == 4'hA && s == 3'd6)) t = {t, " R7"};
        else t = {t, " R6"};
        return t;
    endfunction

    initial begin
        for (int k = 0; k < 128; k++) begin gm[k] = 0; mem[k] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(insn_ready && !done && !wr_en, "R1", "reset state",
              {29'd0, insn_ready, done, wr_en}, 32'h4);

        // Sweep every sub-operation of both groups over several counts.
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 8; s++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    for (int rep = 0; rep < 2; rep++) begin
                        logic [3:0] grp; logic [3:0] c;
                        grp = (g == 0) ? 4'hB : 4'hA;
                        c = (ci == 0) ? 4'd0 : (ci == 1) ? 4'd1 : (ci == 2) ? 4'd5 : 4'd15;
                        fill((rep + s) % 3);
                        run_word(enc(grp, c, 3'(s), 7'($urandom() % 128), 7'($urandom() % 128),
                                     7'($urandom() % 128)), tag_of(grp, 3'(s)));
                    end
                end
            end
        end

        // Index wrap past 127 and destination wrapping through register 0 (R6, R10).
        fill(0);
        run_word(enc(4'hA, 4'd7, 3'd0, 7'd125, 7'd126, 7'd124), "R6 R10 wrap");
        // Destination overlapping the source, one element ahead (R6).
        fill(2);
        run_word(enc(4'hB, 4'd9, 3'd6, 7'd20, 7'd21, 7'd40), "R6 overlap");
        // Wrapping add and subtract at the extremes (R5).
        fill(1);
        run_word(enc(4'hA, 4'd8, 3'd0, 7'd3, 7'd60, 7'd6), "R5 wrap add");
        fill(1);
        run_word(enc(4'hA, 4'd8, 3'd4, 7'd4, 7'd70, 7'd5), "R5 wrap sub");
        // Immediate extremes: most negative and most positive (R7).
        fill(0);
        run_word(enc(4'hA, 4'd3, 3'd2, 7'd10, 7'd90, 7'h40), "R7 imm -64");
        fill(0);
        run_word(enc(4'hB, 4'd3, 3'd5, 7'd10, 7'd90, 7'h3F), "R7 imm +63");
        fill(0);
        run_word(enc(4'hA, 4'd2, 3'd6, 7'd11, 7'd95, 7'h7F), "R7 imm -1");
        // Absolute value against register 0, including the most negative value (R9).
        fill(1);
        run_word(enc(4'hA, 4'd15, 3'd7, 7'd0, 7'd100, 7'd30), "R9 abs");
        // Reduction that starts at register 0 and writes into one of its sources (R8, R10).
        fill(0);
        run_word(enc(4'hA, 4'd15, 3'd3, 7'd0, 7'd5, 7'd77), "R8 sum");
        // Reads of register 0 as sources (R10).
        fill(0);
        run_word(enc(4'hB, 4'd4, 3'd6, 7'd0, 7'd50, 7'd0), "R10 zero source");
        // Unknown groups (R2).
        fill(0);
        run_word(enc(4'h5, 4'd3, 3'd0, 7'd10, 7'd20, 7'd30), "R2 unknown");
        run_word(enc(4'hF, 4'd15, 3'd7, 7'd1, 7'd2, 7'd3), "R2 unknown");
        run_word(enc(4'h9, 4'd0, 3'd1, 7'd1, 7'd2, 7'd3), "R2 unknown");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule